// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences a single DMA channel. Software drives four one-cycle control strobes: status reset, enable, disable and transfer trigger. A configuration word chooses where requests come from, how the external pin is detected, the unit sizes, whether the channel reloads in continuous mode and whether the end interrupt is masked. Two banks hold next-transfer settings (source address, destination address, unit count). Enabling the channel copies the bank named by the select bit into the working registers.

Each accepted request issues one read/write command of one unit on a valid/ready interface to the memory side. When the command completes, both addresses step forward by their own unit size and the remaining count drops by one. When the count runs out, the channel either stops and reports completion, raising the interrupt unless it is masked, or reloads from the selected bank and keeps going. An unaligned address at issue time stops the channel and records a sticky error.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, st_en, st_act, st_err, st_done, irq and cmd_valid are all 0.
- R2: A ctl_swrst strobe clears st_en, st_act, st_err, st_done and irq by the next cycle.
- R3: ctl_seten takes effect only while st_en and st_act are both 0. It then loads source, destination and count from the bank chosen by cfg_bank_sel. A ctl_seten while the channel is enabled does not move the working addresses.
- R4: A ctl_clren strobe withdraws any pending command and clears st_en and st_act on the next cycle. No further commands are issued.
- R5: Each command moves one unit, with cmd_ssize/cmd_dsize equal to cfg_ssize/cfg_dsize (unit bytes = 1 << size, size 0..3). The source steps by its unit bytes and the destination by its unit bytes after each completed unit (cmd_valid and cmd_ready both high). The command holds steady while it is stalled.
- R6: In auto mode (cfg_mode = 0), ctl_trig with st_en = 1 and st_act = 0 starts the run, and all counted units follow with no further request. A ctl_trig while the channel is disabled issues nothing.
- R7: With cfg_reload = 0, exactly the loaded count of units is transferred. After that st_en = 0, st_act = 0 and st_done = 1.
- R8: At a normal end, irq is set only if cfg_end_mask = 0. Once set it stays high until ctl_swrst.
- R9: With cfg_reload = 1, reaching a count of zero reloads source, destination and count from the bank chosen by cfg_bank_sel at that moment. The channel stays enabled, and neither st_done nor irq is raised.
- R10: If the source or destination address is not a multiple of its unit size when a unit would issue, no command is issued, st_err becomes 1 and st_en and st_act become 0.
- R11: In pin mode (cfg_mode = 1) with cfg_pin_level = 0, each rising edge of ext_req counts as one request when cfg_pin_hi = 1, and each falling edge counts when cfg_pin_lo = 1. A steady level issues nothing.
- R12: In pin mode with cfg_pin_level = 1, units keep issuing while the enabled level is present: high with cfg_pin_hi, low with cfg_pin_lo. Issuing stops once the level is removed.
- R13: In peripheral mode (cfg_mode = 2), only periph_req[cfg_psel] requests units, as a high level. Other lines have no effect.
- R14: st_act stays 0 after enabling until the first unit issues. It then stays 1 between requests until the channel ends or is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_swrst | input | 1 | Strobe: clear channel status |
| ctl_seten | input | 1 | Strobe: enable channel and load working set |
| ctl_clren | input | 1 | Strobe: disable channel, abort transfer |
| ctl_trig | input | 1 | Strobe: software start in auto mode |
| cfg_mode | input | 2 | Request source: 0 auto, 1 pin, 2 peripheral |
| cfg_pin_level | input | 1 | Pin detection: 1 level, 0 edge |
| cfg_pin_hi | input | 1 | Pin: high level / rising edge counts |
| cfg_pin_lo | input | 1 | Pin: low level / falling edge counts |
| cfg_psel | input | PSEL_W | Peripheral request line select |
| cfg_reload | input | 1 | Continuous mode: reload at count zero |
| cfg_bank_sel | input | 1 | Bank used for load and reload |
| cfg_end_mask | input | 1 | 1 masks the end interrupt |
| cfg_ssize | input | 2 | Source unit size, log2 bytes |
| cfg_dsize | input | 2 | Destination unit size, log2 bytes |
| bank_we | input | 1 | Bank write strobe |
| bank_idx | input | 1 | Bank written |
| bank_src | input | ADDR_W | Source address written |
| bank_dst | input | ADDR_W | Destination address written |
| bank_cnt | input | CNT_W | Unit count written (0 means 2^CNT_W) |
| ext_req | input | 1 | External request pin (synchronous) |
| periph_req | input | NPER | Peripheral request lines |
| cmd_valid | output | 1 | Unit command pending |
| cmd_src | output | ADDR_W | Command source address |
| cmd_dst | output | ADDR_W | Command destination address |
| cmd_ssize | output | 2 | Command source unit size |
| cmd_dsize | output | 2 | Command destination unit size |
| cmd_ready | input | 1 | Memory side accepts and completes the unit |
| st_en | output | 1 | Status: channel enabled |
| st_act | output | 1 | Status: transfer active |
| st_err | output | 1 | Status: sticky address error |
| st_done | output | 1 | Status: normal end reached |
| irq | output | 1 | End interrupt, held until status reset |

## Verification
The bench sets ADDR_W = 16, CNT_W = 8 and NPER = 4. The narrow address lets every expected source and destination address be written by hand as a short hex constant. The small counts let each run end within a few dozen cycles, so normal end, reload from either bank and repeated reloads all fit into short directed tests. With four peripheral lines the bench can select line 2 and keep its neighbours high, which shows that the selection rejects lines on both sides.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    REQ_AUTO   = 2'd0,
    REQ_PIN    = 2'd1,
    REQ_PERIPH = 2'd2
  } req_mode_e;

  // bytes in one unit for a log2 size code
  function automatic logic [3:0] unit_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // low three address bits against a size code
  function automatic logic misaligned(input logic [2:0] low, input logic [1:0] sz);
    logic [2:0] mask;
    mask = 3'(unit_bytes(sz) - 4'd1);
    return (low & mask) != 3'd0;
  endfunction

  // address after one unit
  function automatic logic [63:0] addr_step(input logic [63:0] a, input logic [1:0] sz);
    return a + 64'(unit_bytes(sz));
  endfunction

endpackage

// File: rtl/dma_bank_regs.sv
module dma_bank_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int NBANK  = 2,
  localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wsrc,
  input  logic [ADDR_W-1:0] wdst,
  input  logic [CNT_W-1:0]  wcnt,
  input  logic [IDX_W-1:0]  rsel,
  output logic [ADDR_W-1:0] rsrc,
  output logic [ADDR_W-1:0] rdst,
  output logic [CNT_W-1:0]  rcnt
);

  logic [ADDR_W-1:0] src_r [NBANK];
  logic [ADDR_W-1:0] dst_r [NBANK];
  logic [CNT_W-1:0]  cnt_r [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_r[b] <= '0;
        dst_r[b] <= '0;
        cnt_r[b] <= '0;
      end else if (we && (widx == IDX_W'(b))) begin
        src_r[b] <= wsrc;
        dst_r[b] <= wdst;
        cnt_r[b] <= wcnt;
      end
    end
  end

  assign rsrc = src_r[rsel];
  assign rdst = dst_r[rsel];
  assign rcnt = cnt_r[rsel];

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
  import dma_seq_pkg::*;
#(
  parameter int NPER   = 8,
  localparam int PSEL_W = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [1:0]        mode,
  input  logic              level,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic              pin,
  input  logic [NPER-1:0]   periph,
  input  logic [PSEL_W-1:0] psel,
  input  logic              take,
  output logic              hit
);

  logic pin_prev;
  logic edge_pend;
  logic rise, fall, edge_hit, lvl_hit, pin_hit;

  assign rise     = pin && !pin_prev;
  assign fall     = !pin && pin_prev;
  assign edge_hit = (hi_en && rise) || (lo_en && fall);
  assign lvl_hit  = (hi_en && pin) || (lo_en && !pin);
  assign pin_hit  = level ? lvl_hit : edge_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev  <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      pin_prev <= pin;
      if (clr || level) edge_pend <= 1'b0;
      else              edge_pend <= (edge_pend && !take) || edge_hit;
    end
  end

  always_comb begin
    case (req_mode_e'(mode))
      REQ_PIN:    hit = pin_hit;
      REQ_PERIPH: hit = periph[psel];
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swrst,
  input  logic              seten,
  input  logic              clren,
  input  logic              trig,
  input  logic [1:0]        mode,
  input  logic              reload_en,
  input  logic              end_mask,
  input  logic [1:0]        ssize,
  input  logic [1:0]        dsize,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              req_hit,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic              req_take,
  output logic              st_en,
  output logic              st_act,
  output logic              st_err,
  output logic              st_done,
  output logic              irq,
  output logic              unit_done,
  output logic              end_evt,
  output logic              reload_evt,
  output logic              err_evt
);

  logic              en_q, act_q, err_q, done_q, irq_q, vld_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;

  logic is_auto, start_ok, want, bad, quiet, issue, last;

  assign is_auto  = (req_mode_e'(mode) == REQ_AUTO);
  assign quiet    = !clren && !swrst;
  assign start_ok = seten && !en_q && !act_q;
  assign want     = en_q && !vld_q &&
                    (is_auto ? (act_q || trig) : req_hit);
  assign bad      = misaligned(src_q[2:0], ssize) || misaligned(dst_q[2:0], dsize);
  assign issue    = want && !bad && quiet;
  assign err_evt  = want && bad && quiet;
  assign unit_done  = vld_q && cmd_ready && quiet;
  assign last       = unit_done && (cnt_q == CNT_W'(1));
  assign end_evt    = last && !reload_en;
  assign reload_evt = last && reload_en;
  assign req_take   = issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      vld_q  <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else if (swrst) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else if (clren) begin
      en_q  <= 1'b0;
      act_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      if (start_ok) begin
        en_q  <= 1'b1;
        src_q <= ld_src;
        dst_q <= ld_dst;
        cnt_q <= ld_cnt;
      end
      if (issue) begin
        vld_q <= 1'b1;
        act_q <= 1'b1;
      end
      if (err_evt) begin
        err_q <= 1'b1;
        en_q  <= 1'b0;
        act_q <= 1'b0;
      end
      if (unit_done) begin
        vld_q <= 1'b0;
        if (reload_evt) begin
          src_q <= ld_src;
          dst_q <= ld_dst;
          cnt_q <= ld_cnt;
        end else if (end_evt) begin
          en_q   <= 1'b0;
          act_q  <= 1'b0;
          done_q <= 1'b1;
          if (!end_mask) irq_q <= 1'b1;
        end else begin
          src_q <= ADDR_W'(addr_step(64'(src_q), ssize));
          dst_q <= ADDR_W'(addr_step(64'(dst_q), dsize));
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_src   = src_q;
  assign cmd_dst   = dst_q;
  assign st_en     = en_q;
  assign st_act    = act_q;
  assign st_err    = err_q;
  assign st_done   = done_q;
  assign irq       = irq_q;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int NPER   = 8,
  localparam int PSEL_W = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_swrst,
  input  logic              ctl_seten,
  input  logic              ctl_clren,
  input  logic              ctl_trig,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_pin_level,
  input  logic              cfg_pin_hi,
  input  logic              cfg_pin_lo,
  input  logic [PSEL_W-1:0] cfg_psel,
  input  logic              cfg_reload,
  input  logic              cfg_bank_sel,
  input  logic              cfg_end_mask,
  input  logic [1:0]        cfg_ssize,
  input  logic [1:0]        cfg_dsize,
  input  logic              bank_we,
  input  logic              bank_idx,
  input  logic [ADDR_W-1:0] bank_src,
  input  logic [ADDR_W-1:0] bank_dst,
  input  logic [CNT_W-1:0]  bank_cnt,
  input  logic              ext_req,
  input  logic [NPER-1:0]   periph_req,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [1:0]        cmd_ssize,
  output logic [1:0]        cmd_dsize,
  input  logic              cmd_ready,
  output logic              st_en,
  output logic              st_act,
  output logic              st_err,
  output logic              st_done,
  output logic              irq
);

  logic [ADDR_W-1:0] sel_src, sel_dst;
  logic [CNT_W-1:0]  sel_cnt;
  logic              req_hit, req_take;
  logic              unit_done, end_evt, reload_evt, err_evt;

  dma_bank_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NBANK(2)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bank_we),
    .widx (bank_idx),
    .wsrc (bank_src),
    .wdst (bank_dst),
    .wcnt (bank_cnt),
    .rsel (cfg_bank_sel),
    .rsrc (sel_src),
    .rdst (sel_dst),
    .rcnt (sel_cnt)
  );

  dma_req_detect #(.NPER(NPER)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!st_en),
    .mode  (cfg_mode),
    .level (cfg_pin_level),
    .hi_en (cfg_pin_hi),
    .lo_en (cfg_pin_lo),
    .pin   (ext_req),
    .periph(periph_req),
    .psel  (cfg_psel),
    .take  (req_take),
    .hit   (req_hit)
  );

  dma_xfer_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .swrst     (ctl_swrst),
    .seten     (ctl_seten),
    .clren     (ctl_clren),
    .trig      (ctl_trig),
    .mode      (cfg_mode),
    .reload_en (cfg_reload),
    .end_mask  (cfg_end_mask),
    .ssize     (cfg_ssize),
    .dsize     (cfg_dsize),
    .ld_src    (sel_src),
    .ld_dst    (sel_dst),
    .ld_cnt    (sel_cnt),
    .req_hit   (req_hit),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_src   (cmd_src),
    .cmd_dst   (cmd_dst),
    .req_take  (req_take),
    .st_en     (st_en),
    .st_act    (st_act),
    .st_err    (st_err),
    .st_done   (st_done),
    .irq       (irq),
    .unit_done (unit_done),
    .end_evt   (end_evt),
    .reload_evt(reload_evt),
    .err_evt   (err_evt)
  );

  assign cmd_ssize = cfg_ssize;
  assign cmd_dsize = cfg_dsize;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_swrst,
  input logic              ctl_clren,
  input logic              cfg_end_mask,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_src,
  input logic [ADDR_W-1:0] cmd_dst,
  input logic [1:0]        cmd_ssize,
  input logic [1:0]        cmd_dsize,
  input logic              st_en,
  input logic              st_act,
  input logic              st_err,
  input logic              st_done,
  input logic              irq,
  input logic              unit_done,
  input logic              end_evt,
  input logic              reload_evt,
  input logic              err_evt
);

  function automatic logic is_aligned(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << sz) - ADDR_W'(1);
    return (a & m) == '0;
  endfunction

  // R2
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_swrst |=> (!st_en && !st_act && !st_err && !st_done && !irq));

  // R4
  clren_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clren && !ctl_swrst) |=> (!cmd_valid && !st_en && !st_act));

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !ctl_clren && !ctl_swrst) |=>
      (cmd_valid && $stable(cmd_src) && $stable(cmd_dst)));

  // R5
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !end_evt && !reload_evt) |=>
      (cmd_src == $past(cmd_src) + (ADDR_W'(1) << $past(cmd_ssize))));

  // R10
  cmd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (is_aligned(cmd_src, cmd_ssize) && is_aligned(cmd_dst, cmd_dsize)));

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !ctl_swrst) |=> (st_err && !st_en && !st_act));

  // R7
  end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (!st_en && !st_act && st_done));

  // R9
  reload_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (st_en && st_act && !st_done));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(cfg_end_mask));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_swrst) |=> irq);

  // R14
  act_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (st_en && st_act));

endmodule

bind dma_chan_seq dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_swrst   (ctl_swrst),
  .ctl_clren   (ctl_clren),
  .cfg_end_mask(cfg_end_mask),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_src     (cmd_src),
  .cmd_dst     (cmd_dst),
  .cmd_ssize   (cmd_ssize),
  .cmd_dsize   (cmd_dsize),
  .st_en       (st_en),
  .st_act      (st_act),
  .st_err      (st_err),
  .st_done     (st_done),
  .irq         (irq),
  .unit_done   (unit_done),
  .end_evt     (end_evt),
  .reload_evt  (reload_evt),
  .err_evt     (err_evt)
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;

  localparam int AW = 16;
  localparam int CW = 8;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_swrst = 0, ctl_seten = 0, ctl_clren = 0, ctl_trig = 0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_pin_level = 0, cfg_pin_hi = 0, cfg_pin_lo = 0;
  logic [1:0] cfg_psel = 2'd0;
  logic cfg_reload = 0, cfg_bank_sel = 0, cfg_end_mask = 0;
  logic [1:0] cfg_ssize = 2'd0, cfg_dsize = 2'd0;
  logic bank_we = 0, bank_idx = 0;
  logic [AW-1:0] bank_src = '0, bank_dst = '0;
  logic [CW-1:0] bank_cnt = '0;
  logic ext_req = 0;
  logic [NP-1:0] periph_req = '0;
  logic cmd_valid;
  logic [AW-1:0] cmd_src, cmd_dst;
  logic [1:0] cmd_ssize, cmd_dsize;
  logic cmd_ready = 0;
  logic st_en, st_act, st_err, st_done, irq;

  int nchk = 0;
  int nerr = 0;
  int ncmd = 0;
  int cyc = 0;
  bit stall = 0;
  logic [AW-1:0] lsrc [64];
  logic [AW-1:0] ldst [64];
  logic [1:0]    lss  [64];
  logic [1:0]    lds  [64];

  always #5 clk = ~clk;

  dma_chan_seq #(.ADDR_W(AW), .CNT_W(CW), .NPER(NP)) dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_swrst(ctl_swrst), .ctl_seten(ctl_seten), .ctl_clren(ctl_clren), .ctl_trig(ctl_trig),
    .cfg_mode(cfg_mode), .cfg_pin_level(cfg_pin_level), .cfg_pin_hi(cfg_pin_hi),
    .cfg_pin_lo(cfg_pin_lo), .cfg_psel(cfg_psel), .cfg_reload(cfg_reload),
    .cfg_bank_sel(cfg_bank_sel), .cfg_end_mask(cfg_end_mask),
    .cfg_ssize(cfg_ssize), .cfg_dsize(cfg_dsize),
    .bank_we(bank_we), .bank_idx(bank_idx), .bank_src(bank_src),
    .bank_dst(bank_dst), .bank_cnt(bank_cnt),
    .ext_req(ext_req), .periph_req(periph_req),
    .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_ssize(cmd_ssize), .cmd_dsize(cmd_dsize), .cmd_ready(cmd_ready),
    .st_en(st_en), .st_act(st_act), .st_err(st_err), .st_done(st_done), .irq(irq)
  );

  // memory-side responder: ready one cycle after valid unless stalled
  always @(negedge clk) begin
    cmd_ready <= cmd_valid && !cmd_ready && !stall;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && cmd_valid && cmd_ready) begin
      lsrc[ncmd % 64] <= cmd_src;
      ldst[ncmd % 64] <= cmd_dst;
      lss[ncmd % 64]  <= cmd_ssize;
      lds[ncmd % 64]  <= cmd_dsize;
      ncmd <= ncmd + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: ctl_swrst = 1;
      1: ctl_seten = 1;
      2: ctl_clren = 1;
      default: ctl_trig = 1;
    endcase
    @(negedge clk);
    ctl_swrst = 0; ctl_seten = 0; ctl_clren = 0; ctl_trig = 0;
  endtask

  task automatic wr_bank(input logic idx, input logic [AW-1:0] s,
                         input logic [AW-1:0] d, input logic [CW-1:0] c);
    @(negedge clk);
    bank_we = 1; bank_idx = idx; bank_src = s; bank_dst = d; bank_cnt = c;
    @(negedge clk);
    bank_we = 0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk);
    ext_req = v;
    wait_n(6);
  endtask

  task automatic t_reset;
    chk("R1", "st_en", st_en, 0);
    chk("R1", "st_act", st_act, 0);
    chk("R1", "st_err", st_err, 0);
    chk("R1", "st_done", st_done, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_auto;
    int b;
    cfg_mode = 2'd0; cfg_reload = 0; cfg_end_mask = 0; cfg_bank_sel = 0;
    cfg_ssize = 2'd2; cfg_dsize = 2'd1;
    wr_bank(0, 16'h0100, 16'h0200, 8'd3);
    strobe(0);
    b = ncmd;
    strobe(3);
    wait_n(5);
    chk("R6", "trig while disabled cmds", ncmd - b, 0);
    chk("R6", "trig while disabled valid", cmd_valid, 0);
    strobe(1);
    chk("R14", "act before first unit", st_act, 0);
    strobe(3);
    wait_n(20);
    chk("R7", "auto unit count", ncmd - b, 3);
    chk("R5", "src0", lsrc[b], 16'h0100);
    chk("R5", "src1", lsrc[b+1], 16'h0104);
    chk("R5", "src2", lsrc[b+2], 16'h0108);
    chk("R5", "dst1", ldst[b+1], 16'h0202);
    chk("R5", "dst2", ldst[b+2], 16'h0204);
    chk("R5", "ssize", lss[b], 2);
    chk("R5", "dsize", lds[b], 1);
    chk("R7", "en after end", st_en, 0);
    chk("R7", "act after end", st_act, 0);
    chk("R7", "done after end", st_done, 1);
    chk("R8", "irq unmasked", irq, 1);
    wait_n(5);
    chk("R8", "irq held", irq, 1);
    strobe(0);
    chk("R2", "done cleared", st_done, 0);
    chk("R2", "irq cleared", irq, 0);
  endtask

  task automatic t_mask;
    int b;
    cfg_mode = 2'd0; cfg_end_mask = 1; cfg_ssize = 2'd0; cfg_dsize = 2'd0;
    wr_bank(0, 16'h0010, 16'h0020, 8'd2);
    strobe(0);
    b = ncmd;
    strobe(1);
    strobe(3);
    wait_n(15);
    chk("R7", "masked run units", ncmd - b, 2);
    chk("R8", "done while masked", st_done, 1);
    chk("R8", "irq masked", irq, 0);
    cfg_end_mask = 0;
    wait_n(3);
    chk("R8", "irq stays low after unmask", irq, 0);
    strobe(0);
  endtask

  task automatic t_edge;
    int b;
    cfg_mode = 2'd1; cfg_pin_level = 0; cfg_pin_hi = 1; cfg_pin_lo = 0;
    cfg_ssize = 2'd0; cfg_dsize = 2'd0; cfg_reload = 0;
    wr_bank(0, 16'h0040, 16'h0080, 8'd3);
    ext_req = 0;
    strobe(0);
    b = ncmd;
    strobe(1);
    wait_n(5);
    chk("R14", "idle enabled act", st_act, 0);
    chk("R11", "no edge no cmd", ncmd - b, 0);
    pin_set(1);
    chk("R11", "rising edge one unit", ncmd - b, 1);
    chk("R14", "act between requests", st_act, 1);
    wait_n(6);
    chk("R11", "high level ignored", ncmd - b, 1);
    pin_set(0);
    chk("R11", "falling ignored", ncmd - b, 1);
    pin_set(1);
    chk("R11", "second rising", ncmd - b, 2);
    strobe(1);
    pin_set(0);
    pin_set(1);
    chk("R3", "seten while enabled keeps address", lsrc[b+2], 16'h0042);
    chk("R7", "edge run done", st_done, 1);
    cfg_pin_hi = 0; cfg_pin_lo = 1;
    strobe(0);
    b = ncmd;
    strobe(1);
    pin_set(0);
    chk("R11", "falling edge counts", ncmd - b, 1);
    chk("R3", "seten reloads bank", lsrc[b], 16'h0040);
    pin_set(1);
    chk("R11", "rising ignored with lo only", ncmd - b, 1);
    strobe(0);
  endtask

  task automatic t_level;
    int b;
    cfg_mode = 2'd1; cfg_pin_level = 1; cfg_pin_hi = 1; cfg_pin_lo = 0;
    ext_req = 0;
    wr_bank(0, 16'h0500, 16'h0600, 8'd5);
    strobe(0);
    b = ncmd;
    strobe(1);
    stall = 1;
    @(negedge clk) ext_req = 1;
    wait_n(4);
    chk("R5", "stalled command held", cmd_valid, 1);
    ext_req = 0;
    wait_n(1);
    stall = 0;
    wait_n(8);
    chk("R12", "stops when level removed", ncmd - b, 1);
    ext_req = 1;
    wait_n(30);
    chk("R12", "level runs remaining units", ncmd - b, 5);
    chk("R7", "level run done", st_done, 1);
    ext_req = 0;
    strobe(0);
  endtask

  task automatic t_periph;
    int b;
    cfg_mode = 2'd2; cfg_psel = 2'd2; cfg_pin_level = 0;
    wr_bank(0, 16'h0700, 16'h0800, 8'd2);
    strobe(0);
    b = ncmd;
    strobe(1);
    periph_req = 4'b1011;
    wait_n(10);
    chk("R13", "unselected lines ignored", ncmd - b, 0);
    periph_req = 4'b0100;
    wait_n(20);
    chk("R13", "selected line units", ncmd - b, 2);
    chk("R13", "periph run done", st_done, 1);
    periph_req = '0;
    strobe(0);
  endtask

  task automatic t_reload;
    int b;
    cfg_mode = 2'd1; cfg_pin_level = 0; cfg_pin_hi = 1; cfg_pin_lo = 0;
    cfg_reload = 1; cfg_bank_sel = 0; cfg_end_mask = 0;
    ext_req = 0;
    wr_bank(0, 16'h0010, 16'h0020, 8'd2);
    wr_bank(1, 16'h0300, 16'h0400, 8'd2);
    strobe(0);
    b = ncmd;
    strobe(1);
    pin_set(1); pin_set(0);
    cfg_bank_sel = 1;
    pin_set(1); pin_set(0);
    chk("R9", "en after reload", st_en, 1);
    chk("R9", "no done on reload", st_done, 0);
    chk("R9", "no irq on reload", irq, 0);
    pin_set(1); pin_set(0);
    chk("R9", "reloaded src from bank1", lsrc[b+2], 16'h0300);
    chk("R9", "reloaded dst from bank1", ldst[b+2], 16'h0400);
    pin_set(1); pin_set(0);
    chk("R9", "second unit after reload", lsrc[b+3], 16'h0301);
    chk("R9", "en after second reload", st_en, 1);
    stall = 1;
    @(negedge clk) ext_req = 1;
    wait_n(3);
    chk("R4", "pending before clear", cmd_valid, 1);
    strobe(2);
    chk("R4", "valid withdrawn", cmd_valid, 0);
    chk("R4", "en cleared", st_en, 0);
    chk("R4", "act cleared", st_act, 0);
    stall = 0;
    wait_n(6);
    pin_set(0); pin_set(1);
    chk("R4", "no units after clear", ncmd - b, 4);
    ext_req = 0;
    cfg_reload = 0; cfg_bank_sel = 0;
    strobe(0);
  endtask

  task automatic t_err;
    int b;
    cfg_mode = 2'd0; cfg_ssize = 2'd1; cfg_dsize = 2'd0;
    wr_bank(0, 16'h0101, 16'h0200, 8'd2);
    strobe(0);
    b = ncmd;
    strobe(1);
    strobe(3);
    wait_n(5);
    chk("R10", "no unit on misaligned", ncmd - b, 0);
    chk("R10", "err set", st_err, 1);
    chk("R10", "en cleared", st_en, 0);
    chk("R10", "act cleared", st_act, 0);
    chk("R10", "valid low", cmd_valid, 0);
    strobe(0);
    chk("R2", "err cleared", st_err, 0);
  endtask

  initial begin
    wait_n(3);
    t_reset;
    @(negedge clk) rst_n = 1;
    wait_n(2);
    t_auto;
    t_mask;
    t_edge;
    t_level;
    t_periph;
    t_reload;
    t_err;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule